// File: doc/BRIEF.md
# Fractional-Rate Realtime Counter

This block maintains a 64-bit free-running time count whose nominal rate is 6.144 MHz, which is a 32.768 kHz reference scaled by 375/2. The block runs on a system clock whose frequency depends on the board. Two mechanisms advance the count. The fine path adds a programmable fraction (numerator over denominator) on every system-clock cycle. The coarse path takes a slow reference tick and re-anchors the count on each such tick, so that fine-path rounding never accumulates.

The slow tick has two possible sources. One is an external crystal tick, which is synchronized into the system-clock domain and edge-detected. The other is an internal tick made by dividing the system clock by 610. A two-bit strap input chooses the source: any nonzero value selects the internal divider. In that case the effective rate is the system clock times 75/244, and software loads that fraction.

Software writes the two fraction values through a one-cycle valid/address/data port. Typical pairs are:
- 64/125 at 12 MHz
- 768/1625 at 13 MHz
- 8/25 at 19.2 MHz
- 192/625 at 20 MHz
- 384/1625 at 26 MHz
- 256/1125 at 27 MHz
- 4/25 at 38.4 MHz

Top module: `frac_rtc`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the accumulator, the expected-count register, the divider and the synchronizer are cleared, and the fraction is set to numerator 4 and denominator 25.
- R2: On each clock edge outside reset, the accumulator gains the numerator. If the sum is at least the denominator, the denominator is subtracted and the count rises by one. Without a slow tick the count changes by 0 or +1 per cycle, so with the 4/25 default and no slow tick the count is floor(4N/25) after N edges.
- R3: A write with `cfgAddr`=0 loads `cfgData` as the numerator, and one with `cfgAddr`=1 loads it as the denominator. The new value is used from the following edge on, and the edge of the write itself still uses the old fraction.
- R4: A denominator write whose data is zero has no effect: the denominator and the accumulator keep their values.
- R5: An accepted fraction write clears the accumulator on the edge of the write.
- R6: When `strapSel` is 0, the slow tick is the rising edge of `xtalTick` after a two-flop synchronizer. A rise that is set up before edge k is applied at edge k+2. A level that is held high produces exactly one tick.
- R7: When `strapSel` is nonzero, the slow tick comes from a divide-by-610 counter. The first tick lands on the 610th edge after reset and the next ones every 610 edges after that.
- R8: Each slow tick adds 375 to an expected count kept in half-count units. After the tick edge the count equals the expected value halved and rounded down. If the fine result differed, the count is forced to that value and the accumulator is cleared.
- R9: With `strapSel` nonzero and the fraction 75/244, the fine path alone reaches 187 counts at the first tick and 375 at the second, so no correction changes the count.
- R10: When `strapSel` is nonzero, `xtalTick` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgValid | input | 1 | Write strobe for the fraction registers |
| cfgAddr | input | 1 | 0 selects the numerator, 1 selects the denominator |
| cfgData | input | 12 | Fraction value to load |
| strapSel | input | 2 | Slow-reference select: 0 selects the crystal, nonzero selects the internal divider |
| xtalTick | input | 1 | Asynchronous 32 kHz crystal tick |
| count | output | 64 | Realtime count value |

## Verification
A fine step or a fraction write shows on `count` after the same clock edge, so the bench samples on the following falling edge. A crystal rise shows two edges later than its first capture edge. A divider tick shows on the 610th edge after reset. The bench keeps a behavioural model that advances on every rising edge and compares against `count` on every falling edge. The hand-computed checks are placed by counting edges from the release of reset, for example the count before and on the exact edge of a crystal tick, and at edges 609 and 610 of the divider.

// File: rtl/frac_rtc_pkg.sv
package frac_rtc_pkg;

  // Per-cycle strobes from the control half to the datapath half.
  typedef struct packed {
    logic slowTick;   // apply coarse correction this edge
    logic loadNum;    // load numerator from wrVal
    logic loadDen;    // load denominator from wrVal (already screened for zero)
  } rtcStrobe_t;

endpackage

// File: rtl/frac_rtc_ctrl.sv
module frac_rtc_ctrl
  import frac_rtc_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int DIV_N  = 610,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgValid,
  input  logic              cfgAddr,
  input  logic [FRAC_W-1:0] cfgData,
  input  logic [1:0]        strapSel,
  input  logic              xtalTick,
  output rtcStrobe_t        strb,
  output logic [FRAC_W-1:0] wrVal
);

  localparam int DIV_W = $clog2(DIV_N);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_N - 1);

  // Internal slow reference: wraps after DIV_N cycles.
  logic [DIV_W-1:0] divCnt;
  logic             divWrap;

  assign divWrap = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)          divCnt <= '0;
    else if (divWrap) divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  // Crystal tick: SYNC_N synchronizing stages plus one history flop.
  logic [SYNC_N:0] syncPipe;
  logic            xtalRise;

  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else     syncPipe <= {syncPipe[SYNC_N-1:0], xtalTick};
  end

  assign xtalRise = syncPipe[SYNC_N-1] & ~syncPipe[SYNC_N];

  // Strobe decode.
  logic useDivider;
  assign useDivider = (strapSel != 2'b00);
  assign wrVal      = cfgData;

  always_comb begin
    strb.slowTick = useDivider ? divWrap : xtalRise;
    strb.loadNum  = cfgValid && !cfgAddr;
    strb.loadDen  = cfgValid && cfgAddr && (cfgData != '0);
  end

endmodule

// File: rtl/frac_rtc_datapath.sv
module frac_rtc_datapath
  import frac_rtc_pkg::*;
#(
  parameter int FRAC_W    = 12,
  parameter int CNT_W     = 64,
  parameter int HALF_STEP = 375,
  parameter int NUM_RST   = 4,
  parameter int DEN_RST   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  rtcStrobe_t        strb,
  input  logic [FRAC_W-1:0] wrVal,
  output logic [CNT_W-1:0]  count,
  output logic [FRAC_W-1:0] fracNum,
  output logic [FRAC_W-1:0] fracDen,
  output logic [FRAC_W:0]   accVal,
  output logic [CNT_W:0]    expHalf
);

  localparam int ACC_W = FRAC_W + 1;
  localparam int EXP_W = CNT_W + 1;

  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accFine;
  logic             fineCarry;
  logic [CNT_W-1:0] cntFine;
  logic [EXP_W-1:0] expNext;
  logic [CNT_W-1:0] anchor;
  logic             mismatch;
  logic             clearAcc;

  always_comb begin
    accSum    = accVal + ACC_W'(fracNum);
    fineCarry = (accSum >= ACC_W'(fracDen));
    accFine   = fineCarry ? (accSum - ACC_W'(fracDen)) : accSum;
    cntFine   = count + CNT_W'(fineCarry);
    expNext   = expHalf + EXP_W'(HALF_STEP);
    anchor    = expNext[CNT_W:1];
    mismatch  = strb.slowTick && (cntFine != anchor);
    clearAcc  = mismatch || strb.loadNum || strb.loadDen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      accVal  <= '0;
      expHalf <= '0;
      fracNum <= FRAC_W'(NUM_RST);
      fracDen <= FRAC_W'(DEN_RST);
    end else begin
      if (strb.loadNum)  fracNum <= wrVal;
      if (strb.loadDen)  fracDen <= wrVal;
      if (strb.slowTick) expHalf <= expNext;
      count  <= mismatch ? anchor : cntFine;
      accVal <= clearAcc ? '0 : accFine;
    end
  end

endmodule

// File: rtl/frac_rtc.sv
module frac_rtc
  import frac_rtc_pkg::*;
#(
  parameter int FRAC_W    = 12,
  parameter int CNT_W     = 64,
  parameter int DIV_N     = 610,
  parameter int HALF_STEP = 375
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgValid,
  input  logic              cfgAddr,
  input  logic [FRAC_W-1:0] cfgData,
  input  logic [1:0]        strapSel,
  input  logic              xtalTick,
  output logic [CNT_W-1:0]  count
);

  rtcStrobe_t        strb;
  logic [FRAC_W-1:0] wrVal;
  logic [FRAC_W-1:0] fracNum;
  logic [FRAC_W-1:0] fracDen;
  logic [FRAC_W:0]   accVal;
  logic [CNT_W:0]    expHalf;
  logic              tickSeen;
  logic              numSeen;
  logic              denSeen;

  assign tickSeen = strb.slowTick;
  assign numSeen  = strb.loadNum;
  assign denSeen  = strb.loadDen;

  frac_rtc_ctrl #(
    .FRAC_W(FRAC_W),
    .DIV_N (DIV_N),
    .SYNC_N(2)
  ) ctrlI (
    .clk     (clk),
    .rst     (rst),
    .cfgValid(cfgValid),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strapSel(strapSel),
    .xtalTick(xtalTick),
    .strb    (strb),
    .wrVal   (wrVal)
  );

  frac_rtc_datapath #(
    .FRAC_W   (FRAC_W),
    .CNT_W    (CNT_W),
    .HALF_STEP(HALF_STEP)
  ) dpI (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wrVal  (wrVal),
    .count  (count),
    .fracNum(fracNum),
    .fracDen(fracDen),
    .accVal (accVal),
    .expHalf(expHalf)
  );

endmodule

// File: rtl/frac_rtc_chk.sv
module frac_rtc_chk #(
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgValid,
  input logic              cfgAddr,
  input logic [FRAC_W-1:0] cfgData,
  input logic [CNT_W-1:0]  count,
  input logic              tickSeen,
  input logic              numSeen,
  input logic              denSeen,
  input logic [FRAC_W-1:0] fracNum,
  input logic [FRAC_W-1:0] fracDen,
  input logic [FRAC_W:0]   accVal,
  input logic [CNT_W:0]    expHalf
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && accVal == '0 && expHalf == '0 &&
                    fracNum == FRAC_W'(4) && fracDen == FRAC_W'(25)));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !tickSeen |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  assert_num_load_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgValid && !cfgAddr) |=> (fracNum == $past(cfgData)));

  assert_zero_den_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (cfgValid && cfgAddr && cfgData == '0) |=> $stable(fracDen));

  assert_den_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    fracDen != '0);

  assert_write_clears_acc_R5: assert property (@(posedge clk) disable iff (rst)
    (numSeen || denSeen) |=> (accVal == '0));

  assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tickSeen |=> !tickSeen);

  assert_anchor_R8: assert property (@(posedge clk) disable iff (rst)
    tickSeen |=> (count == expHalf[CNT_W:1]));

endmodule

bind frac_rtc frac_rtc_chk #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) chkI (
  .clk     (clk),
  .rst     (rst),
  .cfgValid(cfgValid),
  .cfgAddr (cfgAddr),
  .cfgData (cfgData),
  .count   (count),
  .tickSeen(tickSeen),
  .numSeen (numSeen),
  .denSeen (denSeen),
  .fracNum (fracNum),
  .fracDen (fracDen),
  .accVal  (accVal),
  .expHalf (expHalf)
);

// File: tb/frac_rtc_tb_top.sv
`timescale 1ns/1ps
module frac_rtc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgValid = 1'b0;
  logic        cfgAddr = 1'b0;
  logic [11:0] cfgData = '0;
  logic [1:0]  strapSel = 2'b00;
  logic        xtalTick = 1'b0;
  logic [63:0] count;

  int checkCnt = 0;
  int errCnt   = 0;
  bit modelOn  = 1'b0;

  always #2 clk = ~clk;

  frac_rtc dut_i (
    .clk     (clk),
    .rst     (rst),
    .cfgValid(cfgValid),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strapSel(strapSel),
    .xtalTick(xtalTick),
    .count   (count)
  );

  // Behavioural reference model, advanced on each rising edge.
  longint   mCnt, mExp, fCnt;
  int       mAcc, mNum, mDen, mDiv, aSum;
  bit [2:0] mSync;
  bit       mTick, mCorr;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mExp = 0; mAcc = 0; mNum = 4; mDen = 25; mDiv = 0; mSync = '0;
    end else begin
      mTick = (strapSel != 2'b00) ? (mDiv == 609) : (mSync[1] && !mSync[2]);
      mDiv  = (mDiv == 609) ? 0 : mDiv + 1;
      mSync = {mSync[1:0], xtalTick};
      aSum  = mAcc + mNum;
      fCnt  = mCnt;
      if (aSum >= mDen) begin aSum = aSum - mDen; fCnt = fCnt + 1; end
      mCorr = 1'b0;
      if (mTick) begin
        mExp = mExp + 375;
        if (fCnt != mExp / 2) begin fCnt = mExp / 2; mCorr = 1'b1; end
      end
      mCnt = fCnt;
      mAcc = aSum;
      if (cfgValid && !cfgAddr) begin mNum = int'(cfgData); mAcc = 0; end
      if (cfgValid && cfgAddr && cfgData != 12'd0) begin mDen = int'(cfgData); mAcc = 0; end
      if (mCorr) mAcc = 0;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model comparison on every falling edge (covers R2 and R8 cycle by cycle).
  always @(negedge clk) begin
    if (modelOn) check("R2/R8 model", longint'(count), mCnt);
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(logic [1:0] strap);
    rst = 1'b1; strapSel = strap; xtalTick = 1'b0; cfgValid = 1'b0;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic writeReg(logic addr, int val);
    cfgValid = 1'b1; cfgAddr = addr; cfgData = 12'(val);
    cycles(1);
    cfgValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(2'b00);
    modelOn = 1'b1;
    check("R1 reset count", longint'(count), 0);

    // Default fraction 4/25, crystal idle.
    cycles(25);
    check("R2 default 25 edges", longint'(count), 4);
    cycles(100);
    check("R2 default 125 edges", longint'(count), 20);

    // Zero denominator rejected (edge 126).
    writeReg(1'b1, 0);
    cycles(24);
    check("R4 zero den ignored", longint'(count), 24);

    // Numerator 8 (edge 151), accumulator cleared.
    writeReg(1'b0, 8);
    cycles(3);
    check("R5 acc cleared by write", longint'(count), 24);
    cycles(22);
    check("R3 new numerator 8/25", longint'(count), 32);

    // Crystal reference.
    doReset(2'b00);
    cycles(5);
    xtalTick = 1'b1;
    cycles(2);
    check("R6 no tick before sync", longint'(count), 1);
    cycles(1);
    check("R6 tick on third edge", longint'(count), 187);
    cycles(20);
    check("R6 held level one tick", longint'(count), 190);
    xtalTick = 1'b0;
    cycles(10);

    // Internal divider with default fraction; crystal toggled but ignored.
    doReset(2'b01);
    cycles(300);
    xtalTick = 1'b1;
    cycles(100);
    xtalTick = 1'b0;
    cycles(209);
    check("R10 crystal ignored", longint'(count), 97);
    cycles(1);
    check("R7 first divider tick", longint'(count), 187);
    cycles(610);
    check("R7 second divider tick", longint'(count), 375);

    // Internal divider with 75/244.
    doReset(2'b10);
    writeReg(1'b0, 75);
    writeReg(1'b1, 244);
    cycles(608);
    check("R9 first tick 187", longint'(count), 187);
    cycles(610);
    check("R9 second tick 375", longint'(count), 375);
    cycles(610 * 6);
    check("R9 eighth tick", longint'(count), 1500);

    modelOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

endmodule